// File: doc/BRIEF.md
# Token-Ring Adapter Host Glue Register Block

This block sits between an 8-bit host I/O port and the system interface of a token-ring controller. The host reaches everything through a 16-byte address range. The upper half holds the glue registers: two control registers and a cable-selection register. The lower half is an eight-byte window. A select bit in control register 0 decides what the window shows. When the bit is set, the window forwards accesses to the controller's interface registers. When it is clear, the window shows a read-only identity ROM with two pages: card identity and configuration mirrors on one page, and the station address on the other.

A page-extension bit in control register 1 drives the controller's top register-select line, so controller registers 8 and above can be reached through the same eight window offsets. Each rising edge of the controller's interrupt request sets an internal latch. The host sees that latch as a read-only pending flag, and as a level-sensitive interrupt line gated by an enable bit. The host acknowledges by clearing the enable bit and then setting it again. The block also drives the controller's active-low reset, a ring-speed select and a cable-type select.

Top module: `tr_host_glue`

## Requirements
- R1: After reset, control register 0, control register 1 and the cable register are all zero. As a result the ROM is visible in the window, the controller reset output is low, the host interrupt is low, the speed output is low and the cable output is low.
- R2: The address map is as follows:
  - hostAddr 0..7 is the window.
  - hostAddr 8 is control register 0.
  - hostAddr 9 is control register 1.
  - hostAddr 15 is the cable register.
  - Other addresses read 0.
  
  With control register 0 bit 2 set, a window access at offset k drives sifRd/sifWr with sifAddr = {pageExt, k}, returns sifRdata on reads and forwards hostWdata on writes.
- R3: With control register 0 bit 2 clear and bit 3 clear, window offsets 0..5 read as follows, and offsets 6..7 read 0:
  - offset 0: manufacturer ID 0x4D
  - offset 1: the card type parameter
  - offset 2: the revision parameter
  - offsets 3..5: cfgMirror0, cfgMirror1 and cfgMirror2
- R4: With bit 2 clear and bit 3 set, window offsets 1..6 read the 48-bit station address, most significant byte first. Offsets 0 and 7 read 0.
- R5: While the ROM is mapped, window writes are ignored: sifWr stays low and the ROM contents read back unchanged.
- R6: Control register 1 bit 2 (page extension) drives sifAddr[3], so controller register 8+k is reached at window offset k.
- R7: Control register 0 bit 7 is a read-only pending flag that reflects the interrupt latch. A rising edge on sifIrq sets the latch on the next clock edge. Writes to bit 7 have no effect.
- R8: hostIrq is high exactly while the latch is set and control register 1 bit 1 (interrupt enable) is 1.
- R9: A write to control register 1 that changes bit 1 from 1 to 0 clears the latch. Edges that arrive while the enable is 0 are still latched and raise hostIrq once the enable is set again.
- R10: A sifIrq rising edge in the same cycle as a latch-clearing write leaves the latch set after that clock edge.
- R11: Control register 1 has these fields:
  - bit 0 (not-reset) drives sifResetN; writing 0 to the register holds the controller in reset.
  - bit 3 drives speed16 (1 selects 16 Mb/s, 0 selects 4 Mb/s).
  - bits 7..4 read 0.
- R12: Cable register bit 0 drives cableUtp (1 selects UTP, 0 selects STP). Bits 7..1 read 0.
- R13: Control register 0 reads back bit 2 (interface select) and bit 3 (ROM page) as written. Bits 6..4 and 1..0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 4 | Host byte address |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, valid while hostRd |
| hostIrq | output | 1 | Level-sensitive host interrupt |
| sifAddr | output | 4 | Controller register select, top bit from page extension |
| sifRd | output | 1 | Controller read strobe |
| sifWr | output | 1 | Controller write strobe |
| sifWdata | output | 8 | Controller write data |
| sifRdata | input | 8 | Controller read data |
| sifIrq | input | 1 | Controller interrupt request |
| sifResetN | output | 1 | Controller active-low reset |
| speed16 | output | 1 | Ring speed select, 1 = 16 Mb/s |
| cableUtp | output | 1 | Cable select, 1 = UTP |
| cfgMirror0 | input | 8 | Configuration byte 0 shown in the ROM |
| cfgMirror1 | input | 8 | Configuration byte 1 shown in the ROM |
| cfgMirror2 | input | 8 | Configuration byte 2 shown in the ROM |

## Verification
A wrong window-select or page state shows up on the very next window read: either a ROM byte appears where controller data was expected, or a strobe appears on sifRd/sifWr where none should. A wrong page-extension bit shows on sifAddr[3] in the same cycle as the access. A latch that is wrongly set or cleared shows on the pending bit and on hostIrq one clock after the edge or write that should have caused it. The edge-on-clear collision is the sharpest case, because a lost event would otherwise stay invisible until the next interrupt.

// File: rtl/tr_glue_pkg.sv
package tr_glue_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int WIN_W  = ADDR_W - 1;

  // glue register offsets inside the upper half
  localparam logic [WIN_W-1:0] OFF_CTRL0 = 3'd0;
  localparam logic [WIN_W-1:0] OFF_CTRL1 = 3'd1;
  localparam logic [WIN_W-1:0] OFF_CABLE = 3'd7;

  // control register 0 fields
  localparam int C0_IFSEL   = 2;
  localparam int C0_PAGE    = 3;
  localparam int C0_PENDING = 7;

  // control register 1 fields
  localparam int C1_NRST  = 0;
  localparam int C1_IRQEN = 1;
  localparam int C1_PGEXT = 2;
  localparam int C1_SPEED = 3;

  typedef struct packed {
    logic wrCtrl0;
    logic wrCtrl1;
    logic wrCable;
    logic rdCtrl0;
    logic rdCtrl1;
    logic rdCable;
    logic fwdRd;
    logic fwdWr;
    logic romRd;
  } glueStrobes_t;
endpackage

// File: rtl/tr_glue_ctrl.sv
module tr_glue_ctrl
  import tr_glue_pkg::*;
(
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              ifSel,
  output glueStrobes_t      st
);
  logic inWindow;
  logic [WIN_W-1:0] off;

  assign inWindow = ~hostAddr[ADDR_W-1];
  assign off      = hostAddr[WIN_W-1:0];

  always_comb begin
    st = '0;
    if (inWindow) begin
      // window: controller when selected, ROM otherwise (ROM ignores writes)
      st.fwdRd = hostRd & ifSel;
      st.fwdWr = hostWr & ifSel;
      st.romRd = hostRd & ~ifSel;
    end else begin
      st.wrCtrl0 = hostWr & (off == OFF_CTRL0);
      st.wrCtrl1 = hostWr & (off == OFF_CTRL1);
      st.wrCable = hostWr & (off == OFF_CABLE);
      st.rdCtrl0 = hostRd & (off == OFF_CTRL0);
      st.rdCtrl1 = hostRd & (off == OFF_CTRL1);
      st.rdCable = hostRd & (off == OFF_CABLE);
    end
  end
endmodule

// File: rtl/tr_glue_dp.sv
module tr_glue_dp
  import tr_glue_pkg::*;
#(
  parameter logic [DATA_W-1:0] MANUF_ID     = 8'h4D,
  parameter logic [DATA_W-1:0] CARD_TYPE    = 8'h08,
  parameter logic [DATA_W-1:0] REVISION     = 8'h03,
  parameter logic [47:0]       STATION_ADDR = 48'h42001A2B3C4D
)(
  input  logic              clk,
  input  logic              rstN,
  input  glueStrobes_t      st,
  input  logic [WIN_W-1:0]  off,
  input  logic [3:0]        wdata,
  input  logic [DATA_W-1:0] sifRdata,
  input  logic              sifIrq,
  input  logic [DATA_W-1:0] cfgMirror0,
  input  logic [DATA_W-1:0] cfgMirror1,
  input  logic [DATA_W-1:0] cfgMirror2,
  output logic [DATA_W-1:0] hostRdata,
  output logic              ifSel,
  output logic              pageExt,
  output logic              irqEn,
  output logic              irqLatch,
  output logic              sifResetN,
  output logic              speed16,
  output logic              cableUtp
);
  localparam int SA_BYTES = 6;

  logic romPage;
  logic irqPrev;
  logic irqRise;
  logic clrEvt;
  logic [DATA_W-1:0] romByte;

  // control register 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ifSel   <= 1'b0;
      romPage <= 1'b0;
    end else if (st.wrCtrl0) begin
      ifSel   <= wdata[C0_IFSEL];
      romPage <= wdata[C0_PAGE];
    end
  end

  // control register 1
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sifResetN <= 1'b0;
      irqEn     <= 1'b0;
      pageExt   <= 1'b0;
      speed16   <= 1'b0;
    end else if (st.wrCtrl1) begin
      sifResetN <= wdata[C1_NRST];
      irqEn     <= wdata[C1_IRQEN];
      pageExt   <= wdata[C1_PGEXT];
      speed16   <= wdata[C1_SPEED];
    end
  end

  // cable register
  always_ff @(posedge clk) begin
    if (!rstN)            cableUtp <= 1'b0;
    else if (st.wrCable)  cableUtp <= wdata[0];
  end

  // interrupt latch: set on request edge, cleared by enable falling via write;
  // an edge colliding with the clear wins
  assign irqRise = sifIrq & ~irqPrev;
  assign clrEvt  = st.wrCtrl1 & irqEn & ~wdata[C1_IRQEN];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev  <= 1'b0;
      irqLatch <= 1'b0;
    end else begin
      irqPrev  <= sifIrq;
      irqLatch <= irqRise | (irqLatch & ~clrEvt);
    end
  end

  // identity ROM
  always_comb begin
    romByte = '0;
    if (!romPage) begin
      case (off)
        3'd0: romByte = MANUF_ID;
        3'd1: romByte = CARD_TYPE;
        3'd2: romByte = REVISION;
        3'd3: romByte = cfgMirror0;
        3'd4: romByte = cfgMirror1;
        3'd5: romByte = cfgMirror2;
        default: romByte = '0;
      endcase
    end else begin
      for (int i = 1; i <= SA_BYTES; i++) begin
        if (off == WIN_W'(i))
          romByte = STATION_ADDR[DATA_W*(SA_BYTES+1-i)-1 -: DATA_W];
      end
    end
  end

  // read mux
  always_comb begin
    hostRdata = '0;
    if (st.rdCtrl0) begin
      hostRdata[C0_PENDING] = irqLatch;
      hostRdata[C0_PAGE]    = romPage;
      hostRdata[C0_IFSEL]   = ifSel;
    end else if (st.rdCtrl1) begin
      hostRdata[C1_NRST]  = sifResetN;
      hostRdata[C1_IRQEN] = irqEn;
      hostRdata[C1_PGEXT] = pageExt;
      hostRdata[C1_SPEED] = speed16;
    end else if (st.rdCable) begin
      hostRdata[0] = cableUtp;
    end else if (st.fwdRd) begin
      hostRdata = sifRdata;
    end else if (st.romRd) begin
      hostRdata = romByte;
    end
  end
endmodule

// File: rtl/tr_host_glue.sv
module tr_host_glue
  import tr_glue_pkg::*;
#(
  parameter logic [7:0]  MANUF_ID     = 8'h4D,
  parameter logic [7:0]  CARD_TYPE    = 8'h08,
  parameter logic [7:0]  REVISION     = 8'h03,
  parameter logic [47:0] STATION_ADDR = 48'h42001A2B3C4D
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  hostAddr,
  input  logic        hostRd,
  input  logic        hostWr,
  input  logic [7:0]  hostWdata,
  output logic [7:0]  hostRdata,
  output logic        hostIrq,
  output logic [3:0]  sifAddr,
  output logic        sifRd,
  output logic        sifWr,
  output logic [7:0]  sifWdata,
  input  logic [7:0]  sifRdata,
  input  logic        sifIrq,
  output logic        sifResetN,
  output logic        speed16,
  output logic        cableUtp,
  input  logic [7:0]  cfgMirror0,
  input  logic [7:0]  cfgMirror1,
  input  logic [7:0]  cfgMirror2
);
  glueStrobes_t st;
  logic ifSel;
  logic pageExt;
  logic irqEn;
  logic irqLatch;

  tr_glue_ctrl u_ctrl (
    .hostRd   (hostRd),
    .hostWr   (hostWr),
    .hostAddr (hostAddr),
    .ifSel    (ifSel),
    .st       (st)
  );

  tr_glue_dp #(
    .MANUF_ID     (MANUF_ID),
    .CARD_TYPE    (CARD_TYPE),
    .REVISION     (REVISION),
    .STATION_ADDR (STATION_ADDR)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .off        (hostAddr[WIN_W-1:0]),
    .wdata      (hostWdata[3:0]),
    .sifRdata   (sifRdata),
    .sifIrq     (sifIrq),
    .cfgMirror0 (cfgMirror0),
    .cfgMirror1 (cfgMirror1),
    .cfgMirror2 (cfgMirror2),
    .hostRdata  (hostRdata),
    .ifSel      (ifSel),
    .pageExt    (pageExt),
    .irqEn      (irqEn),
    .irqLatch   (irqLatch),
    .sifResetN  (sifResetN),
    .speed16    (speed16),
    .cableUtp   (cableUtp)
  );

  assign sifRd    = st.fwdRd;
  assign sifWr    = st.fwdWr;
  assign sifAddr  = {pageExt, hostAddr[WIN_W-1:0]};
  assign sifWdata = hostWdata;
  assign hostIrq  = irqLatch & irqEn;
endmodule

// File: rtl/tr_host_glue_chk.sv
module tr_host_glue_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] hostAddr,
  input logic       hostRd,
  input logic       hostWr,
  input logic [7:0] hostWdata,
  input logic       ifSel,
  input logic       irqLatch,
  input logic       sifIrq,
  input logic       sifRd,
  input logic       sifWr,
  input logic [3:0] sifAddr,
  input logic       hostIrq,
  input logic       sifResetN
);
  // R5: ROM-mapped window writes never reach the controller
  assert_rom_write_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !hostAddr[3] && !ifSel) |-> !sifWr);

  // R3: ROM-mapped window reads never strobe the controller
  assert_rom_read_local_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostAddr[3] && !ifSel) |-> !sifRd);

  // R6: page-extension write shows on the top select line next cycle
  assert_ext_line_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 4'h9) |=> (sifAddr[3] == $past(hostWdata[2])));

  // R7: a request edge is captured by the next clock
  assert_edge_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sifIrq && !$past(sifIrq)) |=> irqLatch);

  // R8: disabling the enable drops the host line next cycle
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 4'h9 && !hostWdata[1]) |=> !hostIrq);

  // R11: writing zero to control register 1 holds the controller in reset
  assert_reset_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 4'h9 && hostWdata == 8'h00) |=> !sifResetN);
endmodule

bind tr_host_glue tr_host_glue_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostAddr  (hostAddr),
  .hostRd    (hostRd),
  .hostWr    (hostWr),
  .hostWdata (hostWdata),
  .ifSel     (ifSel),
  .irqLatch  (irqLatch),
  .sifIrq    (sifIrq),
  .sifRd     (sifRd),
  .sifWr     (sifWr),
  .sifAddr   (sifAddr),
  .hostIrq   (hostIrq),
  .sifResetN (sifResetN)
);

// File: tb/sim_tr_host_glue.sv
`timescale 1ns/1ps
module sim_tr_host_glue;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] hostAddr = '0;
  logic       hostRd = 1'b0;
  logic       hostWr = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic       hostIrq;
  logic [3:0] sifAddr;
  logic       sifRd;
  logic       sifWr;
  logic [7:0] sifWdata;
  logic [7:0] sifRdata;
  logic       sifIrq = 1'b0;
  logic       sifResetN;
  logic       speed16;
  logic       cableUtp;

  int checks = 0;
  int errors = 0;
  int sifWrCount = 0;
  logic [3:0] lastSifAddr = '0;
  logic [7:0] lastSifData = '0;
  logic [7:0] rd;

  always #2 clk = ~clk;

  // controller model: register k returns 0xA0 | k
  assign sifRdata = 8'hA0 | {4'h0, sifAddr};

  always @(posedge clk) begin
    if (sifWr) begin
      sifWrCount  <= sifWrCount + 1;
      lastSifAddr <= sifAddr;
      lastSifData <= sifWdata;
    end
  end

  tr_host_glue u0 (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostIrq(hostIrq), .sifAddr(sifAddr),
    .sifRd(sifRd), .sifWr(sifWr), .sifWdata(sifWdata), .sifRdata(sifRdata),
    .sifIrq(sifIrq), .sifResetN(sifResetN), .speed16(speed16), .cableUtp(cableUtp),
    .cfgMirror0(8'hC5), .cfgMirror1(8'h44), .cfgMirror2(8'h70)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    #1 d = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic pulseIrq();
    @(negedge clk);
    sifIrq = 1'b1;
    @(negedge clk);
    sifIrq = 1'b0;
  endtask

  // {write, addr, data, expected, requirement number}
  localparam int NVEC = 32;
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 4'h0, 8'h00, 8'h4D, 4'd3},  // R3 manufacturer
    {1'b0, 4'h1, 8'h00, 8'h08, 4'd3},  // R3 card type
    {1'b0, 4'h2, 8'h00, 8'h03, 4'd3},  // R3 revision
    {1'b0, 4'h3, 8'h00, 8'hC5, 4'd3},  // R3 mirror 0
    {1'b0, 4'h4, 8'h00, 8'h44, 4'd3},
    {1'b0, 4'h5, 8'h00, 8'h70, 4'd3},
    {1'b0, 4'h6, 8'h00, 8'h00, 4'd3},
    {1'b1, 4'h8, 8'h08, 8'h00, 4'd4},  // R4 select page one
    {1'b0, 4'h0, 8'h00, 8'h00, 4'd4},
    {1'b0, 4'h1, 8'h00, 8'h42, 4'd4},  // R4 MSB first
    {1'b0, 4'h2, 8'h00, 8'h00, 4'd4},
    {1'b0, 4'h3, 8'h00, 8'h1A, 4'd4},
    {1'b0, 4'h4, 8'h00, 8'h2B, 4'd4},
    {1'b0, 4'h5, 8'h00, 8'h3C, 4'd4},
    {1'b0, 4'h6, 8'h00, 8'h4D, 4'd4},
    {1'b0, 4'h7, 8'h00, 8'h00, 4'd4},
    {1'b1, 4'h3, 8'hFF, 8'h00, 4'd5},  // R5 write into ROM
    {1'b0, 4'h3, 8'h00, 8'h1A, 4'd5},
    {1'b0, 4'h8, 8'h00, 8'h08, 4'd13}, // R13 readback
    {1'b1, 4'h8, 8'hFF, 8'h00, 4'd13},
    {1'b0, 4'h8, 8'h00, 8'h0C, 4'd13}, // pending not writable (R7)
    {1'b1, 4'h8, 8'h04, 8'h00, 4'd2},  // R2 map controller
    {1'b0, 4'h5, 8'h00, 8'hA5, 4'd2},
    {1'b1, 4'h9, 8'h04, 8'h00, 4'd6},  // R6 page extension
    {1'b0, 4'h2, 8'h00, 8'hAA, 4'd6},
    {1'b0, 4'h9, 8'h00, 8'h04, 4'd11},
    {1'b1, 4'h9, 8'hF5, 8'h00, 4'd11}, // R11 upper bits dropped
    {1'b0, 4'h9, 8'h00, 8'h05, 4'd11},
    {1'b0, 4'hF, 8'h00, 8'h00, 4'd12}, // R12
    {1'b1, 4'hF, 8'h01, 8'h00, 4'd12},
    {1'b0, 4'hF, 8'h00, 8'h01, 4'd12},
    {1'b0, 4'hA, 8'h00, 8'h00, 4'd2}   // unused glue address
  };

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 sifResetN", {7'b0, sifResetN}, 8'h00);
    check("R1 hostIrq",   {7'b0, hostIrq},   8'h00);
    check("R1 speed16",   {7'b0, speed16},   8'h00);
    check("R1 cableUtp",  {7'b0, cableUtp},  8'h00);
    busRead(4'h8, rd); check("R1 ctrl0", rd, 8'h00);
    busRead(4'h9, rd); check("R1 ctrl1", rd, 8'h00);
    busRead(4'h0, rd); check("R1 rom visible", rd, 8'h4D);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][24]) busWrite(VEC[i][23:20], VEC[i][19:12]);
      else begin
        busRead(VEC[i][23:20], rd);
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), rd, VEC[i][11:4]);
      end
    end

    // R5: no controller write happened while ROM was mapped
    check("R5 no sifWr", 8'(sifWrCount), 8'd0);
    // R2/R6 forwarded write to register 8+6
    busWrite(4'h6, 8'h5A);
    check("R2 fwd count", 8'(sifWrCount), 8'd1);
    check("R6 fwd addr",  {4'h0, lastSifAddr}, 8'h0E);
    check("R2 fwd data",  lastSifData, 8'h5A);
    // R11/R12 outputs
    check("R11 reset released", {7'b0, sifResetN}, 8'h01);
    check("R11 speed 4M", {7'b0, speed16}, 8'h00);
    check("R12 UTP", {7'b0, cableUtp}, 8'h01);
    busWrite(4'h9, 8'h08);
    check("R11 speed 16M", {7'b0, speed16}, 8'h01);
    check("R11 reset held", {7'b0, sifResetN}, 8'h00);
    busWrite(4'hF, 8'h00);
    check("R12 STP", {7'b0, cableUtp}, 8'h00);

    // interrupt path
    busWrite(4'h9, 8'h03);
    check("R8 idle irq", {7'b0, hostIrq}, 8'h00);
    pulseIrq();
    check("R7 latch hostIrq", {7'b0, hostIrq}, 8'h01);
    busRead(4'h8, rd); check("R7 pending", rd, 8'h84);
    busWrite(4'h9, 8'h01);
    check("R9 cleared irq", {7'b0, hostIrq}, 8'h00);
    busRead(4'h8, rd); check("R9 pending cleared", rd, 8'h04);
    busWrite(4'h9, 8'h03);
    check("R9 reenable no irq", {7'b0, hostIrq}, 8'h00);
    busWrite(4'h9, 8'h01);
    pulseIrq();
    check("R8 disabled gate", {7'b0, hostIrq}, 8'h00);
    busRead(4'h8, rd); check("R9 latched while disabled", rd, 8'h84);
    busWrite(4'h9, 8'h03);
    check("R9 irq after enable", {7'b0, hostIrq}, 8'h01);
    // R10: edge collides with the clearing write
    @(negedge clk);
    hostAddr = 4'h9; hostWdata = 8'h01; hostWr = 1'b1; sifIrq = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; sifIrq = 1'b0;
    check("R10 gated after clear", {7'b0, hostIrq}, 8'h00);
    busRead(4'h8, rd); check("R10 latch kept", rd, 8'h84);
    busWrite(4'h9, 8'h03);
    check("R10 event delivered", {7'b0, hostIrq}, 8'h01);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule